// File: doc/BRIEF.md
# Third-Order One-Bit Delta-Sigma Modulator with Noise Notch

The block turns an oversampled, signed fixed-point baseband stream into a single-bit stream that drives a one-bit DAC. One instance serves one of the I or Q paths. On every clock-enable tick it takes one input sample and emits one output bit. Between ticks it holds its loop state, so it can run from a fast clock with a sparse enable.

The loop filter is a chain of three integrators. A weighted sum of the three states feeds a sign comparator. The comparator decision is fed back as plus or minus full scale at the first integrator. A small negative feedback from the third integrator into the second forms a resonator. The resonator moves a pair of noise-transfer zeros off DC to a fixed out-of-band offset, which lowers the quantization noise in the adjacent channel. The default notch constant puts this offset near 114 kHz at a 12.442 MHz tick rate. Every integrator saturates at the limit of its register and never wraps.

Downstream, a low-pass filter over the bit stream recovers the input. The mean of the bits, mapped as 1 to +1 and 0 to -1, equals the input expressed as a fraction of full scale.

Top module: `ds3_notch_mod`

## Requirements
- R1: A synchronous reset clears all three integrators and drives `bit_o` to 0. After a reset, the bit sequence depends only on the inputs given after that reset.
- R2: While `ce` is low, `bit_o` and all loop state hold. Inserting idle cycles between ticks leaves the sequence of bits produced on ticks unchanged.
- R3: On each tick, `bit_o` takes the comparator decision of that tick, where bit 1 means +full scale. A quantizer input of exactly zero gives 1, so the first tick after reset produces 1.
- R4: For a constant `din` (two's complement, full scale = 2^(IN_W-1)) with magnitude up to 0.55 of full scale, the mean of 4096 bits taken after 256 settling ticks, mapped to +1/-1, matches din/2^(IN_W-1) within 0.01. The first integrator never moves against the output bit: it does not rise after a 1 and does not fall after a 0.
- R5: The integrators saturate and never wrap, so no tick changes the first integrator by more than twice full scale. At plus and minus 0.6 of full scale, the bit mean still matches the input within 0.01.
- R6: For a sinusoid with amplitude 0.5 and a period of 4096 ticks, a 256-tap moving average of the bit stream follows the sinusoid within 0.05. The comparison allows for the gain and the 127.5-tick delay of the averager.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; one loop step per high cycle |
| din | input | IN_W | Signed input sample, full scale 2^(IN_W-1) |
| bit_o | output | 1 | Output bit, 1 = +full scale, 0 = -full scale |

## Verification
The no-wrap and feedback-direction properties assume the loop stays stable. That holds only while the input magnitude stays below about 0.7 of full scale. The stimulus therefore keeps DC levels at or below 0.6 and uses a sinusoid with amplitude 0.5. The hold property assumes `ce` changes only away from the active edge. The bench drives every input one time unit after the edge. Equivalence under idle gaps is judged by comparing two runs of the same block, one without gaps and one with them.

// File: rtl/ds3_notch_mod.sv
module ds3_notch_mod #(
  parameter int IN_W    = 16,
  parameter int GUARD   = 12,
  parameter int CF      = 16,
  parameter int C1      = 49152,
  parameter int C2      = 12288,
  parameter int C3      = 1024,
  parameter int NOTCH_G = 219
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic [IN_W-1:0] din,
  output logic            bit_o
);
  localparam int SW = IN_W + GUARD;
  localparam int PW = SW + CF + 4;
  localparam int FS = 1 << (IN_W - 1);
  localparam logic signed [PW-1:0] HI = PW'((64'sd1 <<< (SW - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);
  localparam logic signed [PW-1:0] K1 = PW'(C1);
  localparam logic signed [PW-1:0] K2 = PW'(C2);
  localparam logic signed [PW-1:0] K3 = PW'(C3);
  localparam logic signed [PW-1:0] KG = PW'(NOTCH_G);
  localparam logic signed [PW-1:0] FSV = PW'(FS);

  logic signed [SW-1:0] x1, x2, x3;
  logic signed [PW-1:0] u, fb, y, gt, d1, d2, d3;
  logic                 q;

  function automatic logic signed [SW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > HI)      return SW'(HI);
    else if (v < LO) return SW'(LO);
    else             return SW'(v);
  endfunction

  assign u  = PW'($signed(din));
  assign y  = K1 * PW'(x1) + K2 * PW'(x2) + K3 * PW'(x3);
  assign q  = (y >= 0);
  assign fb = q ? FSV : -FSV;
  assign gt = (KG * PW'(x3)) >>> CF;
  assign d1 = PW'(x1) + u - fb;
  assign d2 = PW'(x2) + PW'(x1) - gt;
  assign d3 = PW'(x3) + PW'(x2);

  always_ff @(posedge clk) begin
    if (rst) begin
      x1    <= '0;
      x2    <= '0;
      x3    <= '0;
      bit_o <= 1'b0;
    end else if (ce) begin
      x1    <= sat(d1);
      x2    <= sat(d2);
      x3    <= sat(d3);
      bit_o <= q;
    end
  end
endmodule

module ds3_notch_chk #(
  parameter int SW = 28,
  parameter int FS = 32768
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ce,
  input logic                 bit_o,
  input logic signed [SW-1:0] x1,
  input logic signed [SW-1:0] x2,
  input logic signed [SW-1:0] x3
);
  localparam logic signed [SW:0] STEP = (SW+1)'(2 * FS);
  logic signed [SW:0] x1w;
  assign x1w = (SW+1)'(x1);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (x1 == 0 && x2 == 0 && x3 == 0 && bit_o == 1'b0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(x1) && $stable(x2) && $stable(x3) && $stable(bit_o)));

  assert_fb_direction_R4: assert property (@(posedge clk) disable iff (rst)
    ce |=> (bit_o ? (x1w <= $past(x1w)) : (x1w >= $past(x1w))));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    ce |=> ((x1w - $past(x1w) <= STEP) && ($past(x1w) - x1w <= STEP)));
endmodule

bind ds3_notch_mod ds3_notch_chk #(.SW(SW), .FS(FS)) chk_i (
  .clk(clk), .rst(rst), .ce(ce), .bit_o(bit_o), .x1(x1), .x2(x2), .x3(x3)
);

// File: tb/ds3_notch_mod_tb.sv
`timescale 1ns/1ps
module ds3_notch_mod_tb_top;
  localparam int IN_W = 16;
  localparam real FSR = 32768.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic [IN_W-1:0] din = '0;
  logic bit_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ds3_notch_mod dut_i (.clk(clk), .rst(rst), .ce(ce), .din(din), .bit_o(bit_o));

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%f expected=%f", req, act, exp);
    end
  endtask

  task automatic step(input logic e);
    ce = e;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ce = 1'b0;
    step(1'b0);
    step(1'b0);
    rst = 1'b0;
  endtask

  task automatic set_in(input real f);
    din = IN_W'($rtoi(f * FSR));
  endtask

  task automatic t_reset_first();
    set_in(0.3);
    do_reset();
    check(bit_o == 1'b0, "R1 reset bit", real'(bit_o), 0.0);
    step(1'b1);
    check(bit_o == 1'b1, "R3 first tick", real'(bit_o), 1.0);
  endtask

  task automatic t_dc(input real f, input string req);
    int ones = 0;
    real m;
    set_in(f);
    do_reset();
    for (int i = 0; i < 256; i++) step(1'b1);
    for (int i = 0; i < 4096; i++) begin
      step(1'b1);
      ones += int'(bit_o);
    end
    m = (2.0 * ones - 4096.0) / 4096.0;
    check((m - f < 0.01) && (f - m < 0.01), req, m, f);
  endtask

  task automatic t_gaps();
    logic [299:0] ref_b;
    int mism = 0;
    bit moved = 1'b0;
    logic hold;
    set_in(0.3);
    do_reset();
    for (int i = 0; i < 300; i++) begin
      step(1'b1);
      ref_b[i] = bit_o;
    end
    do_reset();
    for (int i = 0; i < 300; i++) begin
      hold = bit_o;
      for (int g = 0; g < (i % 4); g++) begin
        step(1'b0);
        if (bit_o !== hold) moved = 1'b1;
      end
      step(1'b1);
      if (bit_o !== ref_b[i]) mism++;
    end
    check(!moved, "R2 hold while idle", real'(moved), 0.0);
    check(mism == 0, "R2 gap equivalence", real'(mism), 0.0);
  endtask

  task automatic t_restart();
    logic [63:0] a;
    int mism = 0;
    set_in(-0.2);
    do_reset();
    for (int i = 0; i < 64; i++) begin
      step(1'b1);
      a[i] = bit_o;
    end
    for (int i = 0; i < 100; i++) step(1'b1);
    do_reset();
    check(bit_o == 1'b0, "R1 mid-run reset bit", real'(bit_o), 0.0);
    for (int i = 0; i < 64; i++) begin
      step(1'b1);
      if (bit_o !== a[i]) mism++;
    end
    check(mism == 0, "R1 restart sequence", real'(mism), 0.0);
  endtask

  task automatic t_sine();
    localparam real TWO_PI = 6.283185307179586;
    logic [255:0] win = '0;
    int ones = 0;
    real avg, expv, gain;
    gain = $sin(3.141592653589793 / 16.0) / (3.141592653589793 / 16.0);
    do_reset();
    for (int k = 0; k < 3 * 4096; k++) begin
      set_in(0.5 * $sin(TWO_PI * k / 4096.0));
      step(1'b1);
      ones = ones - int'(win[255]) + int'(bit_o);
      win = {win[254:0], bit_o};
      if (k >= 2 * 4096 && (k % 256) == 0) begin
        avg = (2.0 * ones - 256.0) / 256.0;
        expv = 0.5 * gain * $sin(TWO_PI * (k - 127.5) / 4096.0);
        check((avg - expv < 0.05) && (expv - avg < 0.05), "R6 sine tracking", avg, expv);
      end
    end
  endtask

  initial begin
    t_reset_first();
    t_dc(0.0, "R4 dc zero");
    t_dc(0.25, "R4 dc +0.25");
    t_dc(-0.4, "R4 dc -0.4");
    t_dc(0.55, "R4 dc +0.55");
    t_dc(0.6, "R5 dc +0.6");
    t_dc(-0.6, "R5 dc -0.6");
    t_gaps();
    t_restart();
    t_sine();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule